// File: doc/BRIEF.md
# SDRAM Write Timing Checker

A passive monitor that watches the already-decoded command stream of a single-data-rate SDRAM and reports every command that breaks a write-path timing or ordering rule. Each bank is tracked separately. The monitor knows whether the bank is idle, open, recovering from a write burst or precharging. It keeps down-counters for activate-to-write delay, minimum open time, write recovery and precharge time. It also models the precharge that a write with auto-precharge starts inside the device, where no PRE appears on the bus. The bank stays blocked until the recovery time and the precharge time after the final data beat have both passed.

The command stream is a valid-qualified input with no ready signal. The monitor accepts one command on every cycle that `cmd_valid` is high, and it never applies back-pressure. It drives nothing onto the memory bus. A violation is reported as a single-cycle pulse, together with a reason code and the number of the offending bank. The timing values and the burst length are parameters, counted in clock cycles. The defaults are 4 banks, tRCD 3, tWR 2, tRP 3, tRAS 7 and burst length 4.

Top module: `sdr_wr_checker`

## Requirements
- R1: A command is taken only on a cycle with `cmd_valid` high. The `cmd_op` encoding is 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 burst stop. Codes 6 and 7, and any cycle with `cmd_valid` low, have no effect. `cmd_a10` high on a write selects auto-precharge.
- R2: The verdict for a command is registered on the clock edge that samples the command. `viol` is high for that one following cycle, with `viol_code` (1 illegal, 2 bank busy in auto-precharge, 3 early activate, 4 tRCD, 5 tWR, 6 tRAS) and `viol_bank`. When there is no violation, all three outputs are zero.
- R3: These commands give code 1: a write, read or burst stop to a bank that is not open (idle, or in an explicit precharge), and an activate to a bank that is already open.
- R4: A write issued fewer than TRCD cycles after the activate of its bank gives code 4.
- R5: A precharge issued fewer than BL-1+TWR cycles after the latest write to its bank gives code 5. The final beat falls BL-1 cycles after the write.
- R6: Two cases give code 6: a precharge issued fewer than TRAS cycles after the activate, and an auto-precharge write whose internal precharge would start, BL-1+TWR cycles after the write, before TRAS has elapsed.
- R7: After an accepted auto-precharge write, any read, write, precharge or burst stop to that bank within BL+TWR-1+TRP cycles gives code 2.
- R8: An activate gives code 3 in two cases: within BL+TWR-1+TRP cycles of an auto-precharge write, or within TRP cycles of an explicit precharge. An activate after either window is legal.
- R9: A precharge to an idle bank, or to a bank already in an explicit precharge, is a legal no-op.
- R10: When one command breaks several rules, a single code is reported, in this order: 1, 2, 3, 4, 5, 6.
- R11: A flagged command does not change the tracked state or counters of its bank.
- R12: A command to one bank does not change the state or timing of any other bank.
- R13: After reset, every bank is idle and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the SDRAM command bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Decoded command code |
| cmd_bank | input | 2 | Bank address of the command |
| cmd_a10 | input | 1 | Address bit 10; selects auto-precharge on a write |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason for the violation |
| viol_bank | output | 2 | Bank of the violating command |

## Verification
Every verdict appears on the edge that samples the command, so the bench drives a command at the falling edge and reads `viol`, `viol_code` and `viol_bank` just after the next rising edge. The bench advances one command or no-op per cycle, so a command placed d steps after an activate or a write lies exactly d cycles later. This lets each window be probed at the last cycle that is still illegal and at the first cycle that is legal. After each flagged command, the bench issues a later command whose verdict depends on the bank's state. This shows that the flagged command left the bank unchanged, and that commands to other banks did not disturb it.

// File: rtl/sdr_wchk_pkg.sv
package sdr_wchk_pkg;

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_BST = 3'd5;

  // lower value wins when several rules fail at once
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_ILLEGAL   = 3'd1,
    ERR_BUSY      = 3'd2,
    ERR_EARLY_ACT = 3'd3,
    ERR_TRCD      = 3'd4,
    ERR_TWR       = 3'd5,
    ERR_TRAS      = 3'd6
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_WRITING = 2'd2,
    ST_PRECH   = 2'd3
  } bst_e;

endpackage

// File: rtl/sdr_wchk_bank.sv
module sdr_wchk_bank
  import sdr_wchk_pkg::*;
#(
  parameter int unsigned TRCD = 3,
  parameter int unsigned TWR  = 2,
  parameter int unsigned TRP  = 3,
  parameter int unsigned TRAS = 7,
  parameter int unsigned BL   = 4,
  parameter int unsigned CW   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [2:0] op,
  input  logic       a10,
  output err_e       err,
  output bst_e       st_o
);

  // a window "illegal while d < N" is loaded with N-1 on the command edge
  localparam logic [CW-1:0] RCD_LD   = CW'(TRCD - 1);
  localparam logic [CW-1:0] RAS_LD   = CW'(TRAS - 1);
  localparam logic [CW-1:0] REC_LD   = CW'(BL + TWR - 2);
  localparam logic [CW-1:0] EPRE_LD  = CW'(TRP - 1);
  localparam logic [CW-1:0] APRE_LD  = CW'(BL + TWR + TRP - 2);
  localparam logic [CW-1:0] WA_SLACK = CW'(BL + TWR - 1);

  bst_e          st_q, eff;
  logic          auto_q;
  logic [CW-1:0] rcd_q, ras_q, rec_q, pre_q;
  logic          open_b;
  err_e          blk_err;

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  // state as seen this cycle, with expired windows already collapsed
  always_comb begin
    eff = st_q;
    if (st_q == ST_WRITING && rec_q == '0) eff = ST_ACTIVE;
    if (st_q == ST_PRECH && pre_q == '0)   eff = ST_IDLE;
  end

  assign open_b  = (eff == ST_ACTIVE) || (eff == ST_WRITING);
  assign blk_err = auto_q ? ERR_BUSY : ERR_ILLEGAL;
  assign st_o    = eff;

  always_comb begin
    err = ERR_NONE;
    if (hit) begin
      case (op)
        OP_ACT: begin
          if (eff == ST_PRECH)  err = ERR_EARLY_ACT;
          else if (open_b)      err = ERR_ILLEGAL;
        end
        OP_WR: begin
          if (eff == ST_IDLE)                   err = ERR_ILLEGAL;
          else if (eff == ST_PRECH)             err = blk_err;
          else if (rcd_q != '0)                 err = ERR_TRCD;
          else if (a10 && (ras_q > WA_SLACK))   err = ERR_TRAS;
        end
        OP_RD, OP_BST: begin
          if (eff == ST_IDLE)        err = ERR_ILLEGAL;
          else if (eff == ST_PRECH)  err = blk_err;
        end
        OP_PRE: begin
          if (eff == ST_PRECH && auto_q) err = ERR_BUSY;
          else if (open_b) begin
            if (rec_q != '0)       err = ERR_TWR;
            else if (ras_q != '0)  err = ERR_TRAS;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      auto_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rec_q  <= '0;
      pre_q  <= '0;
    end else begin
      st_q  <= eff;
      rcd_q <= tick(rcd_q);
      ras_q <= tick(ras_q);
      rec_q <= tick(rec_q);
      pre_q <= tick(pre_q);
      if (hit && err == ERR_NONE) begin
        case (op)
          OP_ACT: begin
            st_q   <= ST_ACTIVE;
            auto_q <= 1'b0;
            rcd_q  <= RCD_LD;
            ras_q  <= RAS_LD;
            rec_q  <= '0;
          end
          OP_WR: begin
            if (a10) begin
              st_q   <= ST_PRECH;
              auto_q <= 1'b1;
              pre_q  <= APRE_LD;
              rec_q  <= '0;
            end else begin
              st_q  <= ST_WRITING;
              rec_q <= REC_LD;
            end
          end
          OP_PRE: begin
            if (open_b) begin
              st_q   <= ST_PRECH;
              auto_q <= 1'b0;
              pre_q  <= EPRE_LD;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdr_wchk_report.sv
module sdr_wchk_report
  import sdr_wchk_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned BW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cmd_bank,
  input  err_e          bank_err [NBANK],
  output logic          viol,
  output logic [2:0]    viol_code,
  output logic [BW-1:0] viol_bank
);

  err_e sel;

  always_comb begin
    sel = ERR_NONE;
    for (int i = 0; i < NBANK; i++) begin
      if (cmd_bank == BW'(i)) sel = bank_err[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else begin
      viol      <= (sel != ERR_NONE);
      viol_code <= sel;
      viol_bank <= (sel != ERR_NONE) ? cmd_bank : '0;
    end
  end

endmodule

// File: rtl/sdr_wr_checker.sv
module sdr_wr_checker
  import sdr_wchk_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned TRCD  = 3,
  parameter int unsigned TWR   = 2,
  parameter int unsigned TRP   = 3,
  parameter int unsigned TRAS  = 7,
  parameter int unsigned BL    = 4,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned CW   = $clog2(BL + TWR + TRP + TRAS + TRCD + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  input  logic          cmd_a10,
  output logic          viol,
  output logic [2:0]    viol_code,
  output logic [BW-1:0] viol_bank
);

  logic [NBANK-1:0] hit;
  err_e             bank_err [NBANK];
  bst_e             bank_st  [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign hit[g] = cmd_valid && (cmd_bank == BW'(g));

    sdr_wchk_bank #(
      .TRCD(TRCD), .TWR(TWR), .TRP(TRP), .TRAS(TRAS), .BL(BL), .CW(CW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit[g]),
      .op    (cmd_op),
      .a10   (cmd_a10),
      .err   (bank_err[g]),
      .st_o  (bank_st[g])
    );
  end

  sdr_wchk_report #(.NBANK(NBANK), .BW(BW)) u_report (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_bank  (cmd_bank),
    .bank_err  (bank_err),
    .viol      (viol),
    .viol_code (viol_code),
    .viol_bank (viol_bank)
  );

endmodule

// File: rtl/sdr_wchk_props.sv
module sdr_wchk_props
  import sdr_wchk_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned BW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [BW-1:0] cmd_bank,
  input logic          viol,
  input logic [2:0]    viol_code,
  input logic [BW-1:0] viol_bank,
  input bst_e          bank_st [NBANK]
);

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(cmd_valid));

  // R2
  bank_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_bank == $past(cmd_bank)));

  // R3
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR && bank_st[cmd_bank] == ST_IDLE)
      |=> (viol && viol_code == 3'(ERR_ILLEGAL)));

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT && bank_st[cmd_bank] == ST_ACTIVE)
      |=> (viol && viol_code == 3'(ERR_ILLEGAL)));

  // R9
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRE && bank_st[cmd_bank] == ST_IDLE) |=> !viol);

  // R12
  bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_bank == '0) && bank_st[0] == ST_ACTIVE)
      |=> (bank_st[0] == ST_ACTIVE));

endmodule

bind sdr_wr_checker sdr_wchk_props #(.NBANK(NBANK), .BW(BW)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .viol      (viol),
  .viol_code (viol_code),
  .viol_bank (viol_bank),
  .bank_st   (bank_st)
);

// File: tb/sim_sdr_wr_checker.sv
module sim_sdr_wr_checker;

  localparam int CLK_PERIOD = 10;
  localparam int TRAS_TB    = 9;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, BST = 3'd5;
  localparam logic [2:0] E_NONE = 3'd0, E_ILL = 3'd1, E_BUSY = 3'd2,
                         E_EACT = 3'd3, E_RCD = 3'd4, E_WR = 3'd5, E_RAS = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic       cmd_a10;
  logic       viol;
  logic [2:0] viol_code;
  logic [1:0] viol_bank;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdr_wr_checker #(.TRAS(TRAS_TB)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .viol(viol),
    .viol_code(viol_code), .viol_bank(viol_bank)
  );

  task automatic check(input string tag, input logic [2:0] exp_code, input logic [1:0] exp_bank);
    logic       exp_v = (exp_code != E_NONE);
    logic [1:0] eb    = exp_v ? exp_bank : 2'd0;
    checks++;
    if (viol !== exp_v || viol_code !== exp_code || viol_bank !== eb) begin
      errors++;
      $display("FAIL %s: got viol=%0b code=%0d bank=%0d, expected viol=%0b code=%0d bank=%0d",
               tag, viol, viol_code, viol_bank, exp_v, exp_code, eb);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [1:0] bank,
                      input logic a10, input logic [2:0] exp_code, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_bank = bank; cmd_a10 = a10;
    @(posedge clk);
    #1;
    check(tag, exp_code, bank);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b0, NOP, 2'd0, 1'b0, E_NONE, "R2 idle");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = NOP; cmd_bank = 2'd0; cmd_a10 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R13 reset outputs", E_NONE, 2'd0);
    step(1'b1, WR, 2'd2, 1'b0, E_ILL, "R13 bank idle after reset");
  endtask

  task automatic t_illegal();
    do_reset();
    step(1'b1, WR,  2'd1, 1'b0, E_ILL, "R3 write to idle");
    step(1'b1, BST, 2'd1, 1'b0, E_ILL, "R3 burst stop to idle");
    step(1'b1, RD,  2'd2, 1'b0, E_ILL, "R3 read to idle");
    step(1'b1, ACT, 2'd2, 1'b0, E_NONE, "R3 activate");
    nops(2);
    step(1'b1, RD,  2'd2, 1'b0, E_NONE, "R3 read to open");
    step(1'b1, BST, 2'd2, 1'b0, E_NONE, "R3 burst stop to open");
  endtask

  task automatic t_trcd();
    do_reset();
    step(1'b1, ACT, 2'd0, 1'b0, E_NONE, "R4 act");
    nops(1);
    step(1'b1, WR, 2'd0, 1'b0, E_RCD,  "R4 write at TRCD-1");
    step(1'b1, WR, 2'd0, 1'b0, E_NONE, "R4 write at TRCD");
  endtask

  task automatic t_twr();
    do_reset();
    step(1'b1, ACT, 2'd2, 1'b0, E_NONE, "R5 act");
    nops(3);
    step(1'b1, WR, 2'd2, 1'b0, E_NONE, "R5 write");
    nops(3);
    step(1'b1, PRE, 2'd2, 1'b0, E_WR,   "R5 pre one cycle early");
    step(1'b1, PRE, 2'd2, 1'b0, E_NONE, "R5 pre on time");
  endtask

  task automatic t_tras_pre();
    do_reset();
    step(1'b1, ACT, 2'd3, 1'b0, E_NONE, "R6 act");
    nops(7);
    step(1'b1, PRE, 2'd3, 1'b0, E_RAS,  "R6 pre at TRAS-1");
    step(1'b1, PRE, 2'd3, 1'b0, E_NONE, "R6 pre at TRAS");
  endtask

  task automatic t_tras_wa();
    do_reset();
    step(1'b1, ACT, 2'd1, 1'b0, E_NONE, "R6 act");
    nops(2);
    step(1'b1, WR, 2'd1, 1'b1, E_RAS,  "R6 auto write too soon for TRAS");
    step(1'b1, WR, 2'd1, 1'b1, E_NONE, "R6 R11 auto write accepted, bank still open");
  endtask

  task automatic t_priority();
    do_reset();
    step(1'b1, ACT, 2'd0, 1'b0, E_NONE, "R10 act");
    nops(2);
    step(1'b1, WR,  2'd0, 1'b0, E_NONE, "R10 write");
    step(1'b1, PRE, 2'd0, 1'b0, E_WR,   "R10 tWR ahead of tRAS");
  endtask

  task automatic t_auto();
    do_reset();
    step(1'b1, ACT, 2'd1, 1'b0, E_NONE, "R7 act");
    nops(3);
    step(1'b1, WR, 2'd1, 1'b1, E_NONE, "R7 auto write");
    nops(1);
    step(1'b1, RD, 2'd1, 1'b0, E_BUSY, "R7 read in auto precharge");
    nops(3);
    step(1'b1, PRE, 2'd1, 1'b0, E_BUSY, "R7 pre in auto precharge");
    step(1'b1, ACT, 2'd1, 1'b0, E_EACT, "R8 act at window-1");
    step(1'b1, ACT, 2'd1, 1'b0, E_NONE, "R8 act at window end");
    nops(2);
    step(1'b1, WR, 2'd1, 1'b0, E_NONE, "R8 write after reopen");
  endtask

  task automatic t_explicit_pre();
    do_reset();
    step(1'b1, PRE, 2'd0, 1'b0, E_NONE, "R9 pre to idle");
    step(1'b1, WR,  2'd0, 1'b0, E_ILL,  "R9 bank still idle");
    step(1'b1, ACT, 2'd0, 1'b0, E_NONE, "R8 act");
    nops(8);
    step(1'b1, PRE, 2'd0, 1'b0, E_NONE, "R8 pre");
    step(1'b1, PRE, 2'd0, 1'b0, E_NONE, "R9 pre during precharge");
    step(1'b1, ACT, 2'd0, 1'b0, E_EACT, "R8 act at TRP-1");
    step(1'b1, ACT, 2'd0, 1'b0, E_NONE, "R8 act at TRP");
  endtask

  task automatic t_isolation();
    do_reset();
    step(1'b1, ACT, 2'd0, 1'b0, E_NONE, "R12 act b0");
    step(1'b1, ACT, 2'd1, 1'b0, E_NONE, "R12 act b1");
    step(1'b1, ACT, 2'd1, 1'b0, E_ILL,  "R3 act to open bank");
    step(1'b1, WR,  2'd0, 1'b0, E_NONE, "R12 b0 write unaffected");
    nops(1);
    step(1'b1, WR,  2'd1, 1'b1, E_NONE, "R12 b1 auto write");
    step(1'b1, WR,  2'd1, 1'b0, E_BUSY, "R7 b1 busy");
    nops(2);
    step(1'b1, PRE, 2'd0, 1'b0, E_NONE, "R12 b0 pre on own timing");
  endtask

  task automatic t_flagged();
    do_reset();
    step(1'b1, ACT, 2'd2, 1'b0, E_NONE, "R11 act");
    nops(1);
    step(1'b1, ACT, 2'd2, 1'b0, E_ILL,  "R11 second act flagged");
    step(1'b1, WR,  2'd2, 1'b0, E_NONE, "R11 tRCD counted from first act");
  endtask

  task automatic t_ignored();
    do_reset();
    step(1'b0, ACT, 2'd3, 1'b0, E_NONE, "R1 invalid act");
    step(1'b1, 3'd6, 2'd3, 1'b0, E_NONE, "R1 reserved code 6");
    step(1'b1, 3'd7, 2'd3, 1'b1, E_NONE, "R1 reserved code 7");
    step(1'b1, WR,  2'd3, 1'b0, E_ILL,  "R1 bank still idle");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_illegal();
    t_trcd();
    t_twr();
    t_tras_pre();
    t_tras_wa();
    t_priority();
    t_auto();
    t_explicit_pre();
    t_isolation();
    t_flagged();
    t_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule